// File: doc/BRIEF.md
# Dual-Window Scanout Address Sequencer

This block produces the fetch addresses that a display controller uses to pull pixels out of memory. It holds two address windows, each a start address and an exclusive ceiling. While scanout runs, the block walks one window in bursts and then moves to the other, so consecutive frames alternate between the two windows. Each finished frame sets a status bit for the window that just ended. Software clears a status bit by writing a one to it.

A new framebuffer position arrives as a base address, a plane offset, an (x, y) origin, a line pitch, a byte-per-pixel count and a line count. The block computes the window addresses from these values. When scanout is stopped, both windows take the new addresses at once. When scanout is running, the new addresses are held back. Each window then takes them only at its own end of frame, which prevents a window from changing in the middle of a frame. A burst is requested only when the downstream pixel FIFO reports enough free space. The burst length and that free-space threshold come from a control word. A control word carrying an illegal burst length is dropped whole.

When scanout is turned off, the frame already in progress is fetched to its ceiling. A frame-done status is then raised and fetching halts.

Top module: `scanout_addr_seq`

## Requirements
- R1: After reset there is no request, all status bits read 0, no update is pending, the burst length is 16 beats and the free-space threshold is 8.
- R2: For an update, the window start is base + offset + y·pitch + x·bytes_per_pixel. The window ceiling is start + lines·pitch. Both are taken modulo 2^ADDR_W.
- R3: An update that arrives while the sequencer is idle loads both windows on the next clock edge, and no update is left pending.
- R4: An update that arrives while the sequencer is running or draining marks both windows dirty and raises `upd_pending`. Each window loads the held addresses only on the clock edge of its own end of frame. `upd_pending` falls once neither window is dirty. A dirty window left when the sequencer goes idle is loaded within one cycle.
- R5: A burst is requested in a cycle only when the sequencer is running or draining and `fifo_free` ≥ threshold. Within a frame, successive requests advance by burst_length·4 bytes.
- R6: A frame of window w ends with the request whose address plus burst_length·4 reaches or passes the ceiling of window w. That request sets status bit w (bit 0 for window 0, bit 1 for window 1). The next request then starts at the other window's start. Scanout always begins at window 0.
- R7: Once `run_en` drops, requests continue until the current frame ends. That end sets status bit 2 (frame done), and no further request follows until `run_en` rises again.
- R8: In the control word, bits [4:0] hold the burst length in beats and bits [15:8] hold the free-space threshold. A burst length other than 1, 2, 4, 8 or 16 causes the whole write to be ignored, and both fields keep their values.
- R9: Status bits clear when written with a one through `sts_clr_mask` while `sts_clr_we` is high. A status event in the same cycle as a clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Scanout enable |
| upd_valid | input | 1 | New framebuffer position this cycle |
| upd_base | input | ADDR_W | Buffer base address |
| upd_offset | input | ADDR_W | Plane offset in bytes |
| upd_x | input | COORD_W | Horizontal origin in pixels |
| upd_y | input | COORD_W | Vertical origin in lines |
| upd_pitch | input | PITCH_W | Line pitch in bytes |
| upd_bpb | input | BPB_W | Bytes per pixel |
| upd_lines | input | COORD_W | Visible line count |
| cfg_we | input | 1 | Control word write strobe |
| cfg_word | input | 16 | Control word: [4:0] burst beats, [15:8] threshold |
| fifo_free | input | FREE_W | Free entries in the pixel FIFO |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 3 | Write-one-to-clear mask for status |
| req_valid | output | 1 | Burst request this cycle |
| req_addr | output | ADDR_W | Byte address of the burst |
| req_beats | output | 5 | Current burst length in beats |
| status | output | 3 | {frame done, end of window 1, end of window 0} |
| upd_pending | output | 1 | Some window still waits for deferred addresses |

## Verification
The bench aims at the edges where a window changes. It checks the last burst of a frame, which must set the right end-of-frame bit and send the next request to the other window's start. A design that swapped windows or compared against the wrong ceiling would fetch past a frame or stop short. An update made mid-scan is followed until both windows have taken it. This exposes a design that reloads a window mid-frame, reloads both windows at the first end of frame, or drops the pending flag early. Illegal burst lengths, a FIFO sitting one entry below the threshold, and a clear that lands on the same cycle as an end of frame are all exercised. The stop sequence is checked both for the tail of the frame it must still fetch and for the silence that must follow the done bit.

// File: rtl/scanout_pkg.sv
package scanout_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_t;

  localparam int CFG_W     = 16;
  localparam int BEAT_LSB  = 0;
  localparam int BEAT_W    = 5;
  localparam int THR_LSB   = 8;
  localparam int THR_W     = 8;
  localparam int STS_W     = 3;
  localparam int STS_EOF0  = 0;
  localparam int STS_EOF1  = 1;
  localparam int STS_DONE  = 2;

  localparam logic [BEAT_W-1:0] BEATS_RST = 5'd16;
  localparam logic [THR_W-1:0]  THR_RST   = 8'd8;

  function automatic logic beats_legal(input logic [BEAT_W-1:0] b);
    return (b != '0) && ((b & (b - 1'b1)) == '0);
  endfunction

endpackage

// File: rtl/scanout_addr_calc.sv
module scanout_addr_calc #(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 12,
  parameter int PITCH_W = 16,
  parameter int BPB_W   = 3
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  offset,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [BPB_W-1:0]   bpb,
  input  logic [COORD_W-1:0] lines,
  output logic [ADDR_W-1:0]  win_start,
  output logic [ADDR_W-1:0]  win_end
);

  localparam int ROW_W = COORD_W + PITCH_W;
  localparam int COL_W = COORD_W + BPB_W;

  logic [ROW_W-1:0]  row_prod;
  logic [COL_W-1:0]  col_prod;
  logic [ROW_W-1:0]  span_prod;
  logic [ADDR_W-1:0] row_off;
  logic [ADDR_W-1:0] col_off;
  logic [ADDR_W-1:0] span;

  always_comb begin
    row_prod  = ROW_W'(y) * ROW_W'(pitch);
    col_prod  = COL_W'(x) * COL_W'(bpb);
    span_prod = ROW_W'(lines) * ROW_W'(pitch);
    row_off   = ADDR_W'(row_prod);
    col_off   = ADDR_W'(col_prod);
    span      = ADDR_W'(span_prod);
    win_start = base + offset + row_off + col_off;
    win_end   = win_start + span;
  end

endmodule

// File: rtl/scanout_burst_cfg.sv
module scanout_burst_cfg
  import scanout_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_word,
  output logic [BEAT_W-1:0]  beats,
  output logic [THR_W-1:0]   thresh
);

  logic [BEAT_W-1:0] beat_field;
  logic [THR_W-1:0]  thr_field;
  logic              accept;

  assign beat_field = cfg_word[BEAT_LSB +: BEAT_W];
  assign thr_field  = cfg_word[THR_LSB +: THR_W];
  assign accept     = cfg_we && beats_legal(beat_field);

  always_ff @(posedge clk) begin
    if (rst) begin
      beats  <= BEATS_RST;
      thresh <= THR_RST;
    end else if (accept) begin
      beats  <= beat_field;
      thresh <= thr_field;
    end
  end

endmodule

// File: rtl/scanout_window_regs.sv
module scanout_window_regs #(
  parameter int ADDR_W = 32,
  parameter int N_WIN  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          upd_valid,
  input  logic [ADDR_W-1:0]             calc_start,
  input  logic [ADDR_W-1:0]             calc_end,
  input  logic                          idle,
  input  logic [N_WIN-1:0]              commit,
  output logic [N_WIN-1:0][ADDR_W-1:0]  win_start,
  output logic [N_WIN-1:0][ADDR_W-1:0]  win_end,
  output logic [N_WIN-1:0]              dirty
);

  logic [ADDR_W-1:0] held_start;
  logic [ADDR_W-1:0] held_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_start <= '0;
      held_end   <= '0;
    end else if (upd_valid && !idle) begin
      held_start <= calc_start;
      held_end   <= calc_end;
    end
  end

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        win_start[i] <= '0;
        win_end[i]   <= '0;
        dirty[i]     <= 1'b0;
      end else if (upd_valid && idle) begin
        win_start[i] <= calc_start;
        win_end[i]   <= calc_end;
        dirty[i]     <= 1'b0;
      end else begin
        if (dirty[i] && (commit[i] || idle)) begin
          win_start[i] <= held_start;
          win_end[i]   <= held_end;
          dirty[i]     <= 1'b0;
        end
        if (upd_valid) begin
          dirty[i] <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/scanout_fetch_seq.sv
module scanout_fetch_seq
  import scanout_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FREE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run_en,
  input  logic [FREE_W-1:0]        fifo_free,
  input  logic [BEAT_W-1:0]        beats,
  input  logic [THR_W-1:0]         thresh,
  input  logic [1:0][ADDR_W-1:0]   win_start,
  input  logic [1:0][ADDR_W-1:0]   win_end,
  input  logic                     sts_clr_we,
  input  logic [STS_W-1:0]         sts_clr_mask,
  output logic                     idle,
  output logic [1:0]               commit,
  output logic                     req_valid,
  output logic [ADDR_W-1:0]        req_addr,
  output logic                     req_win,
  output logic [STS_W-1:0]         status
);

  localparam int CMP_W  = (FREE_W > THR_W) ? FREE_W : THR_W;
  localparam int STEP_W = BEAT_W + 2;

  seq_state_t        state;
  logic              cur_win;
  logic [ADDR_W-1:0] cur_addr;
  logic              fire;
  logic              hit;
  logic [ADDR_W:0]   next_wide;
  logic [ADDR_W-1:0] other_start;
  logic [STS_W-1:0]  set_bits;
  logic [STS_W-1:0]  clr_bits;

  always_comb begin
    fire        = (state != SEQ_IDLE) && (CMP_W'(fifo_free) >= CMP_W'(thresh));
    next_wide   = {1'b0, cur_addr} + (ADDR_W + 1)'({beats, 2'b00});
    hit         = fire && (next_wide >= {1'b0, win_end[cur_win]});
    other_start = win_start[~cur_win];
    commit      = '0;
    commit[cur_win] = hit;
    set_bits    = '0;
    set_bits[STS_EOF0] = hit && !cur_win;
    set_bits[STS_EOF1] = hit && cur_win;
    set_bits[STS_DONE] = hit && (state == SEQ_DRAIN);
    clr_bits    = sts_clr_we ? sts_clr_mask : '0;
  end

  assign idle = (state == SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      cur_win   <= 1'b0;
      cur_addr  <= '0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_win   <= 1'b0;
      status    <= '0;
    end else begin
      req_valid <= fire;
      if (fire) begin
        req_addr <= cur_addr;
        req_win  <= cur_win;
      end
      status <= (status & ~clr_bits) | set_bits;
      unique case (state)
        SEQ_IDLE: begin
          if (run_en) begin
            state    <= SEQ_RUN;
            cur_win  <= 1'b0;
            cur_addr <= win_start[0];
          end
        end
        SEQ_RUN, SEQ_DRAIN: begin
          if (fire) begin
            if (hit) begin
              cur_win  <= ~cur_win;
              cur_addr <= other_start;
            end else begin
              cur_addr <= next_wide[ADDR_W-1:0];
            end
          end
          if (state == SEQ_RUN && !run_en) begin
            state <= SEQ_DRAIN;
          end else if (state == SEQ_DRAIN && hit) begin
            state <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scanout_addr_seq.sv
module scanout_addr_seq
  import scanout_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 12,
  parameter int PITCH_W = 16,
  parameter int BPB_W   = 3,
  parameter int FREE_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_en,
  input  logic                upd_valid,
  input  logic [ADDR_W-1:0]   upd_base,
  input  logic [ADDR_W-1:0]   upd_offset,
  input  logic [COORD_W-1:0]  upd_x,
  input  logic [COORD_W-1:0]  upd_y,
  input  logic [PITCH_W-1:0]  upd_pitch,
  input  logic [BPB_W-1:0]    upd_bpb,
  input  logic [COORD_W-1:0]  upd_lines,
  input  logic                cfg_we,
  input  logic [15:0]         cfg_word,
  input  logic [FREE_W-1:0]   fifo_free,
  input  logic                sts_clr_we,
  input  logic [2:0]          sts_clr_mask,
  output logic                req_valid,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [4:0]          req_beats,
  output logic [2:0]          status,
  output logic                upd_pending
);

  localparam int N_WIN = 2;

  logic [ADDR_W-1:0]             calc_start;
  logic [ADDR_W-1:0]             calc_end;
  logic [N_WIN-1:0][ADDR_W-1:0]  win_start;
  logic [N_WIN-1:0][ADDR_W-1:0]  win_end;
  logic [N_WIN-1:0]              win_dirty;
  logic [N_WIN-1:0]              win_commit;
  logic                          seq_idle;
  logic                          req_win_q;
  logic [BEAT_W-1:0]             beats;
  logic [THR_W-1:0]              thresh;

  scanout_addr_calc #(
    .ADDR_W (ADDR_W),
    .COORD_W(COORD_W),
    .PITCH_W(PITCH_W),
    .BPB_W  (BPB_W)
  ) u_calc (
    .base     (upd_base),
    .offset   (upd_offset),
    .x        (upd_x),
    .y        (upd_y),
    .pitch    (upd_pitch),
    .bpb      (upd_bpb),
    .lines    (upd_lines),
    .win_start(calc_start),
    .win_end  (calc_end)
  );

  scanout_burst_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .cfg_word(cfg_word),
    .beats   (beats),
    .thresh  (thresh)
  );

  scanout_window_regs #(
    .ADDR_W(ADDR_W),
    .N_WIN (N_WIN)
  ) u_win (
    .clk       (clk),
    .rst       (rst),
    .upd_valid (upd_valid),
    .calc_start(calc_start),
    .calc_end  (calc_end),
    .idle      (seq_idle),
    .commit    (win_commit),
    .win_start (win_start),
    .win_end   (win_end),
    .dirty     (win_dirty)
  );

  scanout_fetch_seq #(
    .ADDR_W(ADDR_W),
    .FREE_W(FREE_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .run_en      (run_en),
    .fifo_free   (fifo_free),
    .beats       (beats),
    .thresh      (thresh),
    .win_start   (win_start),
    .win_end     (win_end),
    .sts_clr_we  (sts_clr_we),
    .sts_clr_mask(sts_clr_mask),
    .idle        (seq_idle),
    .commit      (win_commit),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_win     (req_win_q),
    .status      (status)
  );

  assign req_beats   = beats;
  assign upd_pending = |win_dirty;

endmodule

// File: rtl/scanout_seq_chk.sv
module scanout_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              upd_valid,
  input logic              idle,
  input logic              sts_clr_we,
  input logic [2:0]        sts_clr_mask,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_win,
  input logic [4:0]        req_beats,
  input logic [2:0]        status,
  input logic              upd_pending
);

  logic [ADDR_W-1:0] step;
  assign step = ADDR_W'({req_beats, 2'b00});

  assert_beats_legal_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(req_beats) == 1);

  assert_idle_no_req_R5: assert property (@(posedge clk) disable iff (rst)
    idle |=> !req_valid);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(req_valid) && $past(req_win) == req_win &&
     $stable(req_beats) && $past(req_beats, 2) == req_beats)
    |-> req_addr == $past(req_addr) + step);

  assert_pending_set_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !idle) |=> upd_pending);

  assert_eof0_clear_only_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(status[0]) |-> $past(sts_clr_we && sts_clr_mask[0]));

  assert_eof1_clear_only_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(status[1]) |-> $past(sts_clr_we && sts_clr_mask[1]));

  assert_done_stops_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(status[2]) |=> !req_valid);

endmodule

bind scanout_addr_seq scanout_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .upd_valid   (upd_valid),
  .idle        (seq_idle),
  .sts_clr_we  (sts_clr_we),
  .sts_clr_mask(sts_clr_mask),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_win     (req_win_q),
  .req_beats   (req_beats),
  .status      (status),
  .upd_pending (upd_pending)
);

// File: tb/scanout_addr_seq_tb.sv
module scanout_addr_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_base = '0, upd_offset = '0;
  logic [11:0] upd_x = '0, upd_y = '0, upd_lines = '0;
  logic [15:0] upd_pitch = '0;
  logic [2:0]  upd_bpb = '0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_word = '0;
  logic [7:0]  fifo_free = '0;
  logic        sts_clr_we = 1'b0;
  logic [2:0]  sts_clr_mask = '0;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [4:0]  req_beats;
  logic [2:0]  status;
  logic        upd_pending;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit model_on = 0;

  always #2.5 clk = ~clk;

  scanout_addr_seq u_dut (
    .clk(clk), .rst(rst), .run_en(run_en), .upd_valid(upd_valid),
    .upd_base(upd_base), .upd_offset(upd_offset), .upd_x(upd_x), .upd_y(upd_y),
    .upd_pitch(upd_pitch), .upd_bpb(upd_bpb), .upd_lines(upd_lines),
    .cfg_we(cfg_we), .cfg_word(cfg_word), .fifo_free(fifo_free),
    .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask),
    .req_valid(req_valid), .req_addr(req_addr), .req_beats(req_beats),
    .status(status), .upd_pending(upd_pending)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: 0 idle, 1 run, 2 drain
  int          m_st;
  int          m_w;
  logic [31:0] m_addr;
  logic [31:0] m_s [2];
  logic [31:0] m_e [2];
  bit          m_dirty [2];
  logic [31:0] m_hs, m_he;
  int          m_beats, m_thr;
  logic [2:0]  m_sts;
  bit          m_rv;
  logic [31:0] m_ra;

  function automatic logic [31:0] f_start();
    return upd_base + upd_offset + 32'(upd_y) * 32'(upd_pitch) + 32'(upd_x) * 32'(upd_bpb);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_w = 0; m_addr = 0; m_s[0] = 0; m_s[1] = 0; m_e[0] = 0; m_e[1] = 0;
      m_dirty[0] = 0; m_dirty[1] = 0; m_hs = 0; m_he = 0;
      m_beats = 16; m_thr = 8; m_sts = 0; m_rv = 0; m_ra = 0;
    end else begin
      automatic bit fire = (m_st != 0) && (int'(fifo_free) >= m_thr);
      automatic longint nxt = longint'(m_addr) + m_beats * 4;
      automatic bit hit = fire && (nxt >= longint'(m_e[m_w]));
      automatic logic [31:0] os0 = m_s[0];
      automatic logic [31:0] os_other = m_s[1 - m_w];
      automatic logic [31:0] cs = f_start();
      automatic logic [31:0] ce = cs + 32'(upd_lines) * 32'(upd_pitch);
      automatic int old_st = m_st;
      m_rv = fire;
      if (fire) m_ra = m_addr;
      if (sts_clr_we) m_sts = m_sts & ~sts_clr_mask;
      if (hit) begin
        m_sts[m_w] = 1'b1;
        if (old_st == 2) m_sts[2] = 1'b1;
      end
      for (int i = 0; i < 2; i++) begin
        if (upd_valid && old_st == 0) begin
          m_s[i] = cs; m_e[i] = ce; m_dirty[i] = 0;
        end else begin
          if (m_dirty[i] && ((hit && m_w == i) || old_st == 0)) begin
            m_s[i] = m_hs; m_e[i] = m_he; m_dirty[i] = 0;
          end
          if (upd_valid) m_dirty[i] = 1;
        end
      end
      if (upd_valid && old_st != 0) begin m_hs = cs; m_he = ce; end
      if (old_st == 0) begin
        if (run_en) begin m_st = 1; m_w = 0; m_addr = os0; end
      end else begin
        if (fire) begin
          if (hit) begin m_w = 1 - m_w; m_addr = os_other; end
          else m_addr = nxt[31:0];
        end
        if (old_st == 1 && !run_en) m_st = 2;
        else if (old_st == 2 && hit) m_st = 0;
      end
      if (cfg_we && cfg_word[4:0] inside {5'd1, 5'd2, 5'd4, 5'd8, 5'd16}) begin
        m_beats = int'(cfg_word[4:0]); m_thr = int'(cfg_word[15:8]);
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk(req_valid == m_rv, "R5 req_valid vs model", 32'(req_valid), 32'(m_rv));
      if (m_rv) chk(req_addr == m_ra, "R6 req_addr vs model", req_addr, m_ra);
      chk(status == m_sts, "R9 status vs model", 32'(status), 32'(m_sts));
      chk(upd_pending == (m_dirty[0] | m_dirty[1]), "R4 pending vs model",
          32'(upd_pending), 32'(m_dirty[0] | m_dirty[1]));
      chk(int'(req_beats) == m_beats, "R8 beats vs model", 32'(req_beats), 32'(m_beats));
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_update(input logic [31:0] b, input logic [31:0] o, input int x, input int y,
                           input int p, input int bpb, input int lines);
    upd_base = b; upd_offset = o; upd_x = 12'(x); upd_y = 12'(y);
    upd_pitch = 16'(p); upd_bpb = 3'(bpb); upd_lines = 12'(lines); upd_valid = 1;
    step(1);
    upd_valid = 0;
  endtask

  task automatic wait_req(output bit got);
    got = 0;
    for (int i = 0; i < 50; i++) begin
      if (req_valid) begin got = 1; return; end
      step(1);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    bit got;
    bit seen;
    logic [31:0] addrs [6];
    step(3);
    rst = 0;
    model_on = 1;
    step(1);
    // R1 reset state
    chk(req_valid == 0, "R1 no request", 32'(req_valid), 0);
    chk(status == 0, "R1 status clear", 32'(status), 0);
    chk(upd_pending == 0, "R1 nothing pending", 32'(upd_pending), 0);
    chk(req_beats == 16, "R1 burst reset", 32'(req_beats), 16);

    // R8 legal then illegal config
    cfg_word = 16'h0604; cfg_we = 1; step(1); cfg_we = 0;
    chk(req_beats == 4, "R8 legal burst taken", 32'(req_beats), 4);
    cfg_word = 16'h0A03; cfg_we = 1; step(1);
    cfg_word = 16'h0B18; step(1);
    cfg_word = 16'h0C00; step(1); cfg_we = 0;
    chk(req_beats == 4, "R8 illegal burst ignored", 32'(req_beats), 4);

    // R2/R3 idle update: start 0x1034, ceiling 0x1074
    do_update(32'h1000, 32'h10, 2, 1, 32, 2, 2);
    chk(upd_pending == 0, "R3 idle update not pending", 32'(upd_pending), 0);

    // R5/R8 threshold kept at 6: free 5 gives nothing
    fifo_free = 5; run_en = 1;
    seen = 0;
    for (int i = 0; i < 6; i++) begin step(1); if (req_valid) seen = 1; end
    chk(!seen, "R5 below threshold no request", 32'(seen), 0);
    fifo_free = 6;
    wait_req(got);
    chk(got, "R5 request at threshold", 32'(got), 1);
    for (int i = 0; i < 6; i++) begin addrs[i] = req_addr; step(1); end
    chk(addrs[0] == 32'h1034, "R2 first start address", addrs[0], 32'h1034);
    chk(addrs[1] == 32'h1044, "R5 burst step", addrs[1], 32'h1044);
    chk(addrs[3] == 32'h1064, "R5 last burst of frame", addrs[3], 32'h1064);
    chk(addrs[4] == 32'h1034, "R6 switch to window 1 start", addrs[4], 32'h1034);
    chk(status[0] == 1, "R6 eof0 raised", 32'(status), 1);

    // R9 clear
    sts_clr_mask = 3'b111; sts_clr_we = 1; step(1); sts_clr_we = 0;
    step(1);
    // wait until window 1 eof sets, then clear all cleanly
    for (int i = 0; i < 20 && status == 0; i++) step(1);
    sts_clr_we = 1; step(1); sts_clr_we = 0;

    // R4 update while running: start 0x2000, ceiling 0x2040
    do_update(32'h2000, 32'h0, 0, 0, 32, 2, 2);
    chk(upd_pending == 1, "R4 pending after running update", 32'(upd_pending), 1);
    for (int i = 0; i < 30 && status[1:0] == 2'b00; i++) step(1);
    chk(upd_pending == 1, "R4 pending after first eof", 32'(upd_pending), 1);
    for (int i = 0; i < 30 && status[1:0] != 2'b11; i++) step(1);
    chk(upd_pending == 0, "R4 pending clears after both eofs", 32'(upd_pending), 0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin step(1); if (req_valid && req_addr == 32'h2000) seen = 1; end
    chk(seen, "R4 new window address fetched", 32'(seen), 1);

    // R9 clear held on every cycle while an eof occurs: bit still seen
    sts_clr_mask = 3'b011; sts_clr_we = 1;
    seen = 0;
    for (int i = 0; i < 12; i++) begin step(1); if (status[0]) seen = 1; end
    sts_clr_we = 0;
    chk(seen, "R9 set wins over clear", 32'(seen), 1);

    // R7 stop mid frame
    step(1);
    run_en = 0;
    seen = 0;
    for (int i = 0; i < 30 && !status[2]; i++) begin step(1); end
    chk(status[2] == 1, "R7 frame done raised", 32'(status), 4);
    seen = 0;
    for (int i = 0; i < 6; i++) begin step(1); if (req_valid) seen = 1; end
    chk(!seen, "R7 no request after done", 32'(seen), 0);

    // R3 update while idle then restart at window 0
    do_update(32'h3000, 32'h8, 0, 0, 64, 4, 1);
    chk(upd_pending == 0, "R3 idle reload", 32'(upd_pending), 0);
    run_en = 1;
    wait_req(got);
    chk(req_addr == 32'h3008, "R6 restart at window 0", req_addr, 32'h3008);
    step(10);
    run_en = 0;
    step(20);
    finish_run();
  end

endmodule